// File: doc/BRIEF.md
# Temperature Threshold Interrupt Monitor

The monitor sits behind a temperature converter. Each conversion result arrives with a one-cycle valid strobe. The monitor compares the result with two limits that the host programs: an upper (hot) limit and a lower (cool) limit. A run of consecutive over-limit readings must build up in a programmable fault queue before the monitor declares a hot event. This filters out noisy single samples.

After a hot event, the monitor remembers that the sensor is hot. While it is hot, a reading that falls below the cool limit produces a cool event, which gives the two limits hysteresis. Hot and cool events set sticky status bits, which the host clears. Every conversion also starts a short end-of-conversion pulse that clears itself.

A single active-low interrupt line merges the enabled sources. Each source has its own enable.

Top module: `temp_thresh_irq`

## Requirements
- R1: After reset, `irq_n` is 1 and `sts_hot`, `sts_cool`, `hot_state` and `eoc_active` are all 0.
- R2: A reading strictly greater than `hot_limit` counts toward a hot event. A reading equal to `hot_limit` never counts. When the queue is satisfied, `sts_hot` reads 1 from the cycle after the strobe.
- R3: `queue_sel` sets the number of consecutive over-limit readings needed: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6.
- R4: A valid reading at or below `hot_limit` returns the consecutive count to zero.
- R5: A `queue_clr` pulse returns the count to zero. If it coincides with a valid reading, that reading is not counted.
- R6: While `hot_state` is 1, a reading strictly below `cool_limit` and not above `hot_limit`, with `en_cool` at 1, sets `sts_cool` and clears `hot_state`. A later below-cool reading then raises nothing until a new hot event.
- R7: A reading between the two limits raises no event. A below-cool reading raises no event when `en_cool` is 0 or when `hot_state` is 0.
- R8: Once the queue is satisfied, every further consecutive over-limit reading is a new hot event by itself, so it sets `sts_hot` again after a clear.
- R9: Each valid strobe holds `eoc_active` at 1 for exactly `PULSE_CYC` cycles, and a strobe during a pulse restarts the pulse. The pulse drives `irq_n` low only when `en_eoc` is 1.
- R10: `irq_n` is the inverse of the OR of (`sts_hot` and `en_hot`), (`sts_cool` and `en_cool`) and (`eoc_active` and `en_eoc`). Bit 0 of `sts_clr` clears `sts_hot` and bit 1 clears `sts_cool`. An event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | One-cycle strobe marking a new result |
| conv_data | input | TEMP_W | Conversion result, unsigned |
| hot_limit | input | TEMP_W | Upper limit |
| cool_limit | input | TEMP_W | Lower limit |
| queue_sel | input | 2 | Fault-queue depth select |
| queue_clr | input | 1 | Clears the consecutive count |
| en_hot | input | 1 | Hot interrupt enable |
| en_cool | input | 1 | Cool event and interrupt enable |
| en_eoc | input | 1 | End-of-conversion interrupt enable |
| sts_clr | input | 2 | Status clear, bit 0 hot, bit 1 cool |
| sts_hot | output | 1 | Sticky hot status |
| sts_cool | output | 1 | Sticky cool status |
| hot_state | output | 1 | Hot tracking state |
| eoc_active | output | 1 | End-of-conversion pulse in progress |
| irq_n | output | 1 | Active-low merged interrupt |

## Verification
The hardest state to reach is a saturated fault queue at the six-reading depth, with sticky status cleared, at the moment a single further over-limit reading must fire alone. To get there, the stimulus first breaks any earlier run with an at-limit reading. It then delivers exactly six over-limit strobes, clears the status, and sends one more. A behavioural model, updated on every edge, follows the count, the hot tracking and the pulse timer across these sequences. Clears that collide with strobes are also included.

// File: rtl/temp_irq_pkg.sv
package temp_irq_pkg;

   localparam int unsigned QSEL_W    = 2;
   localparam int unsigned MAX_DEPTH = 6;

   typedef logic [QSEL_W-1:0] qsel_t;

   // depth decode for the consecutive-reading filter
   function automatic int unsigned qdepth(input qsel_t sel);
      case (sel)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 4;
         default: return 6;
      endcase
   endfunction

   typedef struct packed {
      logic hot;
      logic cool;
   } evt_t;

endpackage

// File: rtl/tq_fault_queue.sv
module tq_fault_queue
   import temp_irq_pkg::*;
#(
   parameter int unsigned DEPTH_MAX = MAX_DEPTH,
   localparam int unsigned CNT_W    = $clog2(DEPTH_MAX + 1)
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  valid,
   input  logic  above,
   input  logic  clr,
   input  qsel_t sel,
   output logic  hot_evt
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] need;
   logic [CNT_W:0]   inc;

   generate
      if (DEPTH_MAX < MAX_DEPTH) begin : g_bad_depth
         $error("DEPTH_MAX must cover the deepest queue setting");
      end
   endgenerate

   always_comb begin
      need    = CNT_W'(qdepth(sel));
      inc     = {1'b0, cnt_q} + 1'b1;
      cnt_d   = cnt_q;
      hot_evt = 1'b0;
      if (clr) begin
         cnt_d = '0;
      end else if (valid) begin
         if (above) begin
            if (inc >= {1'b0, need}) begin
               cnt_d   = need;
               hot_evt = 1'b1;
            end else begin
               cnt_d = inc[CNT_W-1:0];
            end
         end else begin
            cnt_d = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   // R4: a reading at or below the limit empties the queue
   a_r4_low_reading_resets: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !above && !clr) |=> (cnt_q == '0));
   // R5: host clear empties the queue
   a_r5_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
   // R3: count never passes the deepest setting
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_DEPTH));

endmodule

// File: rtl/tq_hyst_track.sv
module tq_hyst_track (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic above,
   input  logic below,
   input  logic en_cool,
   input  logic hot_evt,
   output logic cool_evt,
   output logic tracking
);

   logic trk_q;

   always_comb begin
      cool_evt = valid && trk_q && below && !above && en_cool;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        trk_q <= 1'b0;
      else if (hot_evt)  trk_q <= 1'b1;
      else if (cool_evt) trk_q <= 1'b0;
   end

   assign tracking = trk_q;

   // R6: tracking only starts from a hot event
   a_r6_track_from_hot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trk_q) |-> $past(hot_evt));
   // R7: without the cool enable tracking never drops
   a_r7_cool_masked_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (trk_q && !en_cool) |=> trk_q);

endmodule

// File: rtl/tq_irq_agg.sv
module tq_irq_agg
   import temp_irq_pkg::*;
#(
   parameter int unsigned PULSE_CYC = 750,
   parameter bit          REG_IRQ   = 1'b0,
   localparam int unsigned PW       = $clog2(PULSE_CYC + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       conv_valid,
   input  evt_t       evt,
   input  logic       en_hot,
   input  logic       en_cool,
   input  logic       en_eoc,
   input  logic [1:0] sts_clr,
   output logic       sts_hot,
   output logic       sts_cool,
   output logic       eoc_active,
   output logic       irq_n
);

   logic hot_q, cool_q;
   logic pend;

   generate
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("PULSE_CYC must be at least one cycle");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hot_q  <= 1'b0;
         cool_q <= 1'b0;
      end else begin
         hot_q  <= evt.hot  | (hot_q  & ~sts_clr[0]);
         cool_q <= evt.cool | (cool_q & ~sts_clr[1]);
      end
   end

   generate
      if (PULSE_CYC == 1) begin : g_eoc_flop
         logic eoc_q;
         always_ff @(posedge clk) begin
            if (!rst_n) eoc_q <= 1'b0;
            else        eoc_q <= conv_valid;
         end
         assign eoc_active = eoc_q;
      end else begin : g_eoc_cnt
         logic [PW-1:0] tmr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)            tmr_q <= '0;
            else if (conv_valid)   tmr_q <= PW'(PULSE_CYC);
            else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
         end
         assign eoc_active = (tmr_q != '0);
      end
   endgenerate

   always_comb begin
      pend = (hot_q & en_hot) | (cool_q & en_cool) | (eoc_active & en_eoc);
   end

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b1;
            else        irq_q <= ~pend;
         end
         assign irq_n = irq_q;
      end else begin : g_irq_comb
         assign irq_n = ~pend;
         // R10: nothing enabled keeps the line released
         a_r10_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_hot && !en_cool && !en_eoc) |-> irq_n);
      end
   endgenerate

   assign sts_hot  = hot_q;
   assign sts_cool = cool_q;

   // R9: every strobe starts the pulse
   a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
      conv_valid |=> eoc_active);
   // R10: status stays until cleared
   a_r10_hot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_q && !sts_clr[0]) |=> hot_q);
   a_r10_cool_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cool_q && !sts_clr[1]) |=> cool_q);

endmodule

// File: rtl/temp_thresh_irq.sv
module temp_thresh_irq
   import temp_irq_pkg::*;
#(
   parameter int unsigned TEMP_W    = 8,
   parameter int unsigned PULSE_CYC = 750,
   parameter bit          REG_IRQ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [TEMP_W-1:0] conv_data,
   input  logic [TEMP_W-1:0] hot_limit,
   input  logic [TEMP_W-1:0] cool_limit,
   input  logic [1:0]        queue_sel,
   input  logic              queue_clr,
   input  logic              en_hot,
   input  logic              en_cool,
   input  logic              en_eoc,
   input  logic [1:0]        sts_clr,
   output logic              sts_hot,
   output logic              sts_cool,
   output logic              hot_state,
   output logic              eoc_active,
   output logic              irq_n
);

   logic above, below;
   evt_t evt;

   generate
      if (TEMP_W < 2) begin : g_bad_width
         $error("TEMP_W must be at least 2");
      end
   endgenerate

   always_comb begin
      above = conv_data > hot_limit;
      below = conv_data < cool_limit;
   end

   tq_fault_queue #(.DEPTH_MAX(MAX_DEPTH)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (conv_valid),
      .above   (above),
      .clr     (queue_clr),
      .sel     (queue_sel),
      .hot_evt (evt.hot)
   );

   tq_hyst_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (conv_valid),
      .above    (above),
      .below    (below),
      .en_cool  (en_cool),
      .hot_evt  (evt.hot),
      .cool_evt (evt.cool),
      .tracking (hot_state)
   );

   tq_irq_agg #(.PULSE_CYC(PULSE_CYC), .REG_IRQ(REG_IRQ)) u_agg (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_valid (conv_valid),
      .evt        (evt),
      .en_hot     (en_hot),
      .en_cool    (en_cool),
      .en_eoc     (en_eoc),
      .sts_clr    (sts_clr),
      .sts_hot    (sts_hot),
      .sts_cool   (sts_cool),
      .eoc_active (eoc_active),
      .irq_n      (irq_n)
   );

   // R2: hot status rises only after a strobe
   a_r2_hot_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_hot) |-> $past(conv_valid));
   // R7: cool status cannot rise while cool events are disabled
   a_r7_cool_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !en_cool |=> !$rose(sts_cool));
   // R6: cool status rises only from the hot state
   a_r6_cool_from_hot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_cool) |-> $past(hot_state));

endmodule

// File: tb/temp_thresh_irq_tb.sv
module temp_thresh_irq_tb;

   localparam int TB_PULSE = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_valid = 1'b0;
   logic [7:0] conv_data = '0;
   logic [7:0] hot_limit = 8'd100;
   logic [7:0] cool_limit = 8'd50;
   logic [1:0] queue_sel = 2'b00;
   logic       queue_clr = 1'b0;
   logic       en_hot = 1'b0, en_cool = 1'b0, en_eoc = 1'b0;
   logic [1:0] sts_clr = 2'b00;
   logic       sts_hot, sts_cool, hot_state, eoc_active, irq_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   temp_thresh_irq #(.TEMP_W(8), .PULSE_CYC(TB_PULSE)) u_dut (
      .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
      .hot_limit(hot_limit), .cool_limit(cool_limit), .queue_sel(queue_sel),
      .queue_clr(queue_clr), .en_hot(en_hot), .en_cool(en_cool), .en_eoc(en_eoc),
      .sts_clr(sts_clr), .sts_hot(sts_hot), .sts_cool(sts_cool),
      .hot_state(hot_state), .eoc_active(eoc_active), .irq_n(irq_n)
   );

   // behavioural reference model
   int m_cnt = 0, m_eoc = 0;
   bit m_trk = 0, m_hot = 0, m_cool = 0;

   always @(posedge clk) begin
      int need;
      bit he, ce;
      if (!rst_n) begin
         m_cnt = 0; m_eoc = 0; m_trk = 0; m_hot = 0; m_cool = 0;
      end else begin
         need = (queue_sel == 0) ? 1 : (queue_sel == 1) ? 2 : (queue_sel == 2) ? 4 : 6;
         he = 0; ce = 0;
         if (queue_clr) m_cnt = 0;
         else if (conv_valid) begin
            if (conv_data > hot_limit) begin
               m_cnt = m_cnt + 1;
               if (m_cnt >= need) begin m_cnt = need; he = 1; end
            end else m_cnt = 0;
         end
         if (conv_valid && m_trk && conv_data < cool_limit &&
             !(conv_data > hot_limit) && en_cool) ce = 1;
         if (he) m_trk = 1; else if (ce) m_trk = 0;
         m_hot  = he | (m_hot & !sts_clr[0]);
         m_cool = ce | (m_cool & !sts_clr[1]);
         if (conv_valid) m_eoc = TB_PULSE;
         else if (m_eoc > 0) m_eoc = m_eoc - 1;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 model sts_hot", sts_hot, m_hot);
         check("R6 model sts_cool", sts_cool, m_cool);
         check("R6 model hot_state", hot_state, m_trk);
         check("R9 model eoc_active", eoc_active, m_eoc > 0);
         check("R10 model irq_n", irq_n,
               !((m_hot && en_hot) || (m_cool && en_cool) || (m_eoc > 0 && en_eoc)));
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic conv(input logic [7:0] v);
      conv_valid = 1'b1; conv_data = v;
      tick();
      conv_valid = 1'b0;
   endtask

   task automatic clr_sts(input logic [1:0] m);
      sts_clr = m; tick(); sts_clr = 2'b00;
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 irq_n", irq_n, 1);
      check("R1 sts_hot", sts_hot, 0);
      check("R1 sts_cool", sts_cool, 0);
      check("R1 hot_state", hot_state, 0);
      check("R1 eoc_active", eoc_active, 0);

      en_hot = 1; en_cool = 1;
      // R2 strict compare
      conv(8'd100);
      check("R2 equal no hot", sts_hot, 0);
      conv(8'd101);
      check("R2 above sets hot", sts_hot, 1);
      check("R10 irq low", irq_n, 0);
      repeat (3) tick();
      check("R10 sticky", sts_hot, 1);
      clr_sts(2'b01);
      check("R10 clear", sts_hot, 0);

      // R3 depth 4
      queue_sel = 2'b10;
      conv(8'd90);
      repeat (3) conv(8'd120);
      check("R3 depth4 after 3", sts_hot, 0);
      conv(8'd120);
      check("R3 depth4 after 4", sts_hot, 1);
      clr_sts(2'b01);

      // R3 depth 6
      queue_sel = 2'b11;
      conv(8'd100);
      repeat (5) conv(8'd130);
      check("R3 depth6 after 5", sts_hot, 0);
      conv(8'd130);
      check("R3 depth6 after 6", sts_hot, 1);
      clr_sts(2'b01);
      // R8 saturated queue fires on one reading
      conv(8'd140);
      check("R8 repeat hot", sts_hot, 1);
      clr_sts(2'b01);

      // R4 low reading breaks the run
      queue_sel = 2'b01;
      conv(8'd90);
      conv(8'd110); conv(8'd80); conv(8'd110);
      check("R4 broken run", sts_hot, 0);
      conv(8'd110);
      check("R4 run completes", sts_hot, 1);
      clr_sts(2'b01);

      // R5 host clear, including a collision with a strobe
      conv(8'd90);
      conv(8'd110);
      queue_clr = 1; tick(); queue_clr = 0;
      conv(8'd110);
      check("R5 cleared run", sts_hot, 0);
      queue_clr = 1; conv(8'd110); queue_clr = 0;
      conv(8'd110);
      check("R5 collided reading ignored", sts_hot, 0);
      conv(8'd110);
      check("R5 run after clear", sts_hot, 1);
      check("R6 hot_state set", hot_state, 1);
      clr_sts(2'b01);

      // R7 between limits, cool disabled
      conv(8'd75);
      check("R7 between no hot", sts_hot, 0);
      check("R7 between no cool", sts_cool, 0);
      en_cool = 0;
      conv(8'd30);
      check("R7 cool masked", sts_cool, 0);
      check("R7 still tracking", hot_state, 1);
      en_cool = 1;
      conv(8'd50);
      check("R6 equal cool no event", sts_cool, 0);
      conv(8'd30);
      check("R6 cool event", sts_cool, 1);
      check("R6 tracking cleared", hot_state, 0);
      clr_sts(2'b10);
      conv(8'd20);
      check("R6 no repeat cool", sts_cool, 0);

      // R10 event beats clear in the same cycle
      queue_sel = 2'b00;
      sts_clr = 2'b01; conv(8'd200); sts_clr = 2'b00;
      check("R10 set wins", sts_hot, 1);
      clr_sts(2'b01);

      // R9 pulse length and mask
      en_hot = 0; en_cool = 0; en_eoc = 1;
      repeat (TB_PULSE + 2) tick();
      check("R9 idle released", irq_n, 1);
      conv(8'd60);
      n = 0;
      while (!irq_n && n < 100) begin n++; tick(); end
      check("R9 pulse length", n, TB_PULSE);
      conv(8'd60);
      repeat (3) tick();
      conv(8'd60);
      n = 0;
      while (eoc_active && n < 100) begin n++; tick(); end
      check("R9 retrigger length", n, TB_PULSE);
      en_eoc = 0;
      conv(8'd60);
      check("R9 masked active", eoc_active, 1);
      check("R9 masked irq", irq_n, 1);
      repeat (TB_PULSE + 2) tick();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule